// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Sequencer

This block keeps a 4-bit-wide DRAM with four column strobes from losing data. An internal timer raises a refresh request once per average row period (the retention interval divided by the row count, about 15.6 us). The requests are kept in a small saturating pending count so that refresh can wait while the access controller is busy. The block asks the access controller for the memory bus with a request/grant pair. Once the queue is full, it also raises an urgent flag.

When the grant arrives, the block runs one refresh cycle on the row strobe, the four column strobes and the address bus. The sequence is picked per cycle by a mode input. The first choice is row-strobe-only refresh, which puts the row from an internal counter on the address bus. The second is column-before-row refresh, which drives no address and lets the DRAM step its own row counter. A device parameter picks the large variant (4096 rows, 64 ms) or the small variant (2048 rows, 32 ms). A one-cycle done pulse closes every cycle, and after it the controller takes its grant back. The DRAM data pins are high-impedance throughout both sequences, so no read data may be captured during a refresh.

Top module: `rfsh_sched`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ras_n` is 1, every bit of `cas_n` is 1, `addr` is 0, and `ref_req`, `ref_urgent` and `ref_done` are 0.
- R2: The first `ref_req` rises exactly `TICK_CYCLES` clock edges after reset is released, and after that one request is added every `TICK_CYCLES` edges. By default `TICK_CYCLES` is the retention interval times the clock rate divided by the row count.
- R3: The pending count goes up by one per request tick and saturates at `MAX_PEND`. `ref_req` is 1 whenever the count is non-zero. `ref_urgent` is 1 exactly when the count equals `MAX_PEND`, so a tick that arrives while the queue is full is dropped.
- R4: A refresh cycle starts only when the block is idle and samples `ref_req` and `ref_gnt` both at 1 on a clock edge. The first strobe change shows on the outputs after that same edge. `ref_gnt` has no effect while no request is pending.
- R5: With `mode_cbr` = 0 (row-only), `ras_n` is 0 for exactly `RAS_W` cycles, all `cas_n` bits stay 1, and `addr` carries the internal row count while `ras_n` is low.
- R6: With `mode_cbr` = 1 (column-before-row), all four `cas_n` bits go to 0 exactly `CAS_LEAD` cycles before `ras_n` falls. Both stay low for `RAS_W` cycles and return to 1 on the same edge, and `addr` is 0 throughout.
- R7: After the strobes are released, all strobes stay high for `PRECH` cycles. Then `ref_done` is 1 for exactly one cycle, and the pending count is lowered on the same edge that raises `ref_done`.
- R8: The row count starts at 0 and advances by one after each row-only cycle only. It wraps to 0 after 4095 when `SMALL_DEV` = 0 and after 2047 when `SMALL_DEV` = 1. The variant changes nothing else.
- R9: `mode_cbr` is sampled only on the edge that starts a cycle. A change while a cycle runs does not alter that cycle's strobe pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cbr | input | 1 | 0 = row-only refresh, 1 = column-before-row refresh |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | At least one refresh pending |
| ref_urgent | output | 1 | Pending queue full |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NUM_CAS | Column strobes, active low, one per data lane |
| addr | output | ROW_W | Row address for row-only refresh |
| ref_done | output | 1 | One-cycle pulse at the end of each refresh |

## Verification
The request line rises on the very edge that ends a timer period, so the bench checks it low after edge `TICK_CYCLES`-1 and high after edge `TICK_CYCLES`, counting edges from reset release. The same edge counting is used for the urgent flag after `MAX_PEND` periods. After the grant is raised, the first strobe change is due one edge later, and the bench checks it at the next falling clock edge. A monitor then measures each phase in whole cycles at falling edges: the column lead, the row pulse and the precharge gap up to `ref_done`. It pops the expected mode and row index from a scoreboard queue at each row-strobe fall. The saturation case is placed between two timer ticks, so that the drop of `ref_urgent` at `ref_done` can only come from the completed refresh.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_ACT  = 2'd2,
    ST_PRE  = 2'd3
  } rfsh_st_e;

  function automatic int unsigned dev_rows(int unsigned small_dev);
    return (small_dev != 0) ? 2048 : 4096;
  endfunction

  function automatic int unsigned dev_interval_ms(int unsigned small_dev);
    return (small_dev != 0) ? 32 : 64;
  endfunction

  // clock cycles between requests: interval spread evenly over all rows
  function automatic int unsigned tick_default(int unsigned small_dev, int unsigned clk_khz);
    return (dev_interval_ms(small_dev) * clk_khz) / dev_rows(small_dev);
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned TICK_CYCLES = 1562
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
  parameter int unsigned MAX_PEND = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fin,
  output logic req,
  output logic urgent
);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] FULL = PW'(MAX_PEND);

  logic [PW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (tick && !fin) begin
      if (cnt != FULL) cnt_n = cnt + 1'b1;
    end else if (fin && !tick) begin
      if (cnt != '0) cnt_n = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      req    <= 1'b0;
      urgent <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      req    <= (cnt_n != '0);
      urgent <= (cnt_n == FULL);
    end
  end

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int unsigned NUM_CAS  = 4,
  parameter int unsigned ROW_W    = 12,
  parameter int unsigned ROWS     = 4096,
  parameter int unsigned CAS_LEAD = 2,
  parameter int unsigned RAS_W    = 4,
  parameter int unsigned PRECH    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               gnt,
  input  logic               mode_cbr,
  output logic               fin,
  output logic               ras_n,
  output logic [NUM_CAS-1:0] cas_n,
  output logic [ROW_W-1:0]   addr,
  output logic               done
);
  localparam int unsigned MAXC_A = (CAS_LEAD > RAS_W) ? CAS_LEAD : RAS_W;
  localparam int unsigned MAXC   = (MAXC_A > PRECH) ? MAXC_A : PRECH;
  localparam int unsigned CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(CAS_LEAD - 1);
  localparam logic [CW-1:0] ACT_LAST  = CW'(RAS_W - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRECH - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  rfsh_st_e         st, st_n;
  logic [CW-1:0]    cnt, cnt_n;
  logic             cbr, cbr_n;
  logic [ROW_W-1:0] row;

  always_comb begin
    st_n  = st;
    cnt_n = cnt + 1'b1;
    cbr_n = cbr;
    fin   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        cnt_n = '0;
        if (req && gnt) begin
          cbr_n = mode_cbr;
          st_n  = mode_cbr ? ST_LEAD : ST_ACT;
        end
      end
      ST_LEAD: if (cnt == LEAD_LAST) begin
        st_n  = ST_ACT;
        cnt_n = '0;
      end
      ST_ACT: if (cnt == ACT_LAST) begin
        st_n  = ST_PRE;
        cnt_n = '0;
      end
      ST_PRE: if (cnt == PRE_LAST) begin
        st_n  = ST_IDLE;
        cnt_n = '0;
        fin   = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
      cbr <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      cbr <= cbr_n;
    end
  end

  // row counter for row-only refresh; the device counts its own rows otherwise
  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
    end else if (fin && !cbr) begin
      row <= (row == ROW_LAST) ? '0 : row + 1'b1;
    end
  end

  // strobes registered from the next state so they line up with it
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_n <= 1'b1;
      cas_n <= '1;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      ras_n <= (st_n != ST_ACT);
      cas_n <= (cbr_n && (st_n == ST_LEAD || st_n == ST_ACT)) ? '0 : '1;
      addr  <= (!cbr_n && st_n == ST_ACT) ? row : '0;
      done  <= fin;
    end
  end

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned SMALL_DEV   = 0,
  parameter int unsigned CLK_KHZ     = 100000,
  parameter int unsigned TICK_CYCLES = tick_default(SMALL_DEV, CLK_KHZ),
  parameter int unsigned MAX_PEND    = 4,
  parameter int unsigned CAS_LEAD    = 2,
  parameter int unsigned RAS_W       = 4,
  parameter int unsigned PRECH       = 3,
  parameter int unsigned NUM_CAS     = 4,
  parameter int unsigned ROW_W       = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_cbr,
  input  logic               ref_gnt,
  output logic               ref_req,
  output logic               ref_urgent,
  output logic               ras_n,
  output logic [NUM_CAS-1:0] cas_n,
  output logic [ROW_W-1:0]   addr,
  output logic               ref_done
);
  localparam int unsigned ROWS = dev_rows(SMALL_DEV);

  logic tick;
  logic fin;

  rfsh_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rfsh_pending #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .fin    (fin),
    .req    (ref_req),
    .urgent (ref_urgent)
  );

  rfsh_seq #(
    .NUM_CAS  (NUM_CAS),
    .ROW_W    (ROW_W),
    .ROWS     (ROWS),
    .CAS_LEAD (CAS_LEAD),
    .RAS_W    (RAS_W),
    .PRECH    (PRECH)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (ref_req),
    .gnt      (ref_gnt),
    .mode_cbr (mode_cbr),
    .fin      (fin),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .addr     (addr),
    .done     (ref_done)
  );

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int unsigned NUM_CAS  = 4,
  parameter int unsigned ROW_W    = 12,
  parameter int unsigned CAS_LEAD = 2,
  parameter int unsigned RAS_W    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req,
  input logic               urgent,
  input logic               gnt,
  input logic               ras_n,
  input logic [NUM_CAS-1:0] cas_n,
  input logic [ROW_W-1:0]   addr,
  input logic               done
);
  logic [15:0] low_cnt;
  logic [15:0] lead_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      lead_cnt <= '0;
    end else begin
      low_cnt  <= !ras_n ? low_cnt + 1'b1 : '0;
      lead_cnt <= (ras_n && cas_n == '0) ? lead_cnt + 1'b1 : '0;
    end
  end

  assert_urgent_has_req_R3: assert property (@(posedge clk) disable iff (rst)
    urgent |-> req);

  assert_start_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (($fell(ras_n) && cas_n == '1) || $fell(cas_n[0])) |-> ($past(gnt) && $past(req)));

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_cnt == 16'(RAS_W)));

  assert_cas_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    (cas_n == '0) || (cas_n == '1));

  assert_cas_lead_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && cas_n == '0) |-> (lead_cnt == 16'(CAS_LEAD)));

  assert_cas_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (cas_n == '1));

  assert_cbr_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (cas_n == '0) |-> (addr == '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind rfsh_sched rfsh_sched_chk #(
  .NUM_CAS  (NUM_CAS),
  .ROW_W    (ROW_W),
  .CAS_LEAD (CAS_LEAD),
  .RAS_W    (RAS_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (ref_req),
  .urgent (ref_urgent),
  .gnt    (ref_gnt),
  .ras_n  (ras_n),
  .cas_n  (cas_n),
  .addr   (addr),
  .done   (ref_done)
);

// File: tb/rfsh_sched_bench.sv
module rfsh_sched_bench;
  localparam int TICK  = 24;
  localparam int MAXP  = 4;
  localparam int LEAD  = 2;
  localparam int RASW  = 3;
  localparam int PRE   = 2;

  typedef struct packed {
    logic        cbr;
    logic [31:0] idx;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_cbr = 1'b0;
  logic        ref_gnt = 1'b0;
  logic        ref_req, ref_urgent, ras_n, ref_done;
  logic [3:0]  cas_n;
  logic [11:0] addr;
  logic        req_s, urg_s, ras_s, done_s;
  logic [3:0]  cas_s;
  logic [11:0] addr_s;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   ro_idx = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rfsh_sched #(.SMALL_DEV(0), .TICK_CYCLES(TICK), .MAX_PEND(MAXP),
    .CAS_LEAD(LEAD), .RAS_W(RASW), .PRECH(PRE)) u_rfsh_sched (
    .clk(clk), .rst(rst), .mode_cbr(mode_cbr), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ras_n(ras_n),
    .cas_n(cas_n), .addr(addr), .ref_done(ref_done));

  rfsh_sched #(.SMALL_DEV(1), .TICK_CYCLES(TICK), .MAX_PEND(MAXP),
    .CAS_LEAD(LEAD), .RAS_W(RASW), .PRECH(PRE)) u_rfsh_sched_small (
    .clk(clk), .rst(rst), .mode_cbr(mode_cbr), .ref_gnt(ref_gnt),
    .ref_req(req_s), .ref_urgent(urg_s), .ras_n(ras_s),
    .cas_n(cas_s), .addr(addr_s), .ref_done(done_s));

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wait_cyc(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  // driver: one granted refresh, expected item pushed to the scoreboard
  task automatic do_ref(input bit m, input bit flip);
    exp_t it;
    while (!ref_req) @(negedge clk);
    mode_cbr = m;
    ref_gnt  = 1'b1;
    it.cbr = m;
    it.idx = 32'(ro_idx);
    q.push_back(it);
    if (!m) ro_idx++;
    @(negedge clk);
    if (m) chk(ras_n && cas_n == 4'h0, "R4", "cbr first strobe (cas_n)", cas_n, 0);
    else   chk(!ras_n && cas_n == 4'hF, "R4", "row-only first strobe (ras_n)", ras_n, 0);
    if (flip) mode_cbr = !m;  // R9 change during the cycle
    while (!ref_done) @(negedge clk);
    ref_gnt = 1'b0;
  endtask

  // monitor: phase lengths and scoreboard compare at each row strobe fall
  bit prev_ras = 1'b1;
  int lead_w = 0, low_w = 0, pre_w = 0;
  always @(negedge clk) begin
    if (!rst) begin
      exp_t it;
      if (prev_ras && !ras_n) begin
        chk(ras_s == ras_n, "R8", "variants strobe alike", ras_s, ras_n);
        if (q.size() == 0) begin
          chk(1'b0, "R4", "refresh with nothing granted", 1, 0);
        end else begin
          it = q.pop_front();
          if (it.cbr) begin
            chk(cas_n == 4'h0, "R6", "cas_n at ras fall", cas_n, 0);
            chk(lead_w == LEAD, "R6", "cas lead cycles", lead_w, LEAD);
            chk(addr == 0, "R6", "addr in cbr", addr, 0);
          end else begin
            chk(cas_n == 4'hF, "R5", "cas_n in row-only", cas_n, 15);
            chk(addr == 12'(it.idx % 4096), "R8", "row addr large", addr, it.idx % 4096);
            chk(addr_s == 12'(it.idx % 2048), "R8", "row addr small", addr_s, it.idx % 2048);
          end
        end
      end
      if (!prev_ras && ras_n) begin
        chk(low_w == RASW, "R5", "ras low width", low_w, RASW);
        chk(cas_n == 4'hF, "R6", "cas released with ras", cas_n, 15);
      end
      if (ref_done) begin
        chk(pre_w == PRE, "R7", "precharge cycles before done", pre_w, PRE);
        chk(done_s == 1'b1, "R7", "small variant done", done_s, 1);
      end
      if (ref_done) pre_w = 0;
      else if (!prev_ras && ras_n) pre_w = 1;
      else if (pre_w != 0) pre_w++;
      lead_w = (ras_n && cas_n == 4'h0) ? lead_w + 1 : 0;
      low_w  = !ras_n ? low_w + 1 : 0;
      prev_ras = ras_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    bit quiet;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ras_n && cas_n == 4'hF && addr == 0, "R1", "strobes in reset", {ras_n, cas_n}, 31);
    chk(!ref_req && !ref_urgent && !ref_done, "R1", "flags in reset",
        {ref_req, ref_urgent, ref_done}, 0);
    rst = 1'b0;
    ref_gnt = 1'b1;  // R4: grant with nothing pending
    @(negedge clk);
    chk(ras_n && cas_n == 4'hF && addr == 0 && !ref_done, "R1", "first cycle out of reset",
        {ras_n, cas_n}, 31);
    quiet = 1'b1;
    while (cyc < TICK - 1) begin
      if (!ras_n || cas_n != 4'hF) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R4", "grant without request ignored", quiet, 1);
    ref_gnt = 1'b0;
    chk(!ref_req, "R2", "req before first period", ref_req, 0);
    @(negedge clk);
    chk(ref_req, "R2", "req at first period", ref_req, 1);
    wait_cyc(MAXP * TICK - 1);
    chk(!ref_urgent, "R3", "urgent one edge early", ref_urgent, 0);
    @(negedge clk);
    chk(ref_urgent && ref_req, "R3", "urgent at full queue", ref_urgent, 1);
    wait_cyc(5 * TICK + 10);  // one extra tick while full
    chk(ras_n, "R4", "no refresh without grant", ras_n, 1);
    do_ref(1'b0, 1'b0);
    chk(!ref_urgent, "R3", "urgent after one refresh (saturated)", ref_urgent, 0);
    chk(ref_req, "R7", "req still pending after done", ref_req, 1);
    do_ref(1'b1, 1'b0);
    do_ref(1'b0, 1'b1);
    do_ref(1'b1, 1'b1);
    do_ref(1'b0, 1'b0);
    do_ref(1'b1, 1'b0);
    for (int i = 0; i < 2060; i++) do_ref(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R4", "scoreboard drained", q.size(), 0);
    summary();
  end

endmodule